// File: doc/BRIEF.md
# PN Despreading Partition Correlator

This block despreads one user's chip stream in a synchronous multi-user receiver. Chip samples arrive in sign-magnitude form at chip precision, one per cycle when `chip_valid` is high. A per-user pseudo-random sequence generator supplies one code bit per accepted chip. That bit flips the sign of the sample, so despreading needs no multiplier. The despread chip is turned into two's complement and summed over a fixed number of chips, which is one partition.

When a partition closes, its sum is shifted down and clamped to the narrower partition precision. It is presented with a one-cycle valid strobe and a hard-decision bit. All users' chips are assumed to be time-aligned, so the block does no delay alignment. Loading a new code seed restarts both the sequence and the partition count.

Top module: `pn_despread_correlator`

## Requirements
- R1: After reset `part_valid`, `part_value` and `part_hard` are 0, the partition count is at the first chip, and the code register holds `RESET_SEED` (default all ones).
- R2: The despread sign of an accepted chip is `chip_in[CHIP_W-1]` XOR the current code bit. The magnitude `chip_in[CHIP_W-2:0]` passes unchanged and is applied as a signed value, so a negative zero contributes 0.
- R3: The code register has 51 stages, bit 0 being stage 1, and the current code bit is bit 0. Each accepted chip shifts the register one place toward bit 0, with new bit 50 = bit 0 XOR bit 3 (stages 1 and 4). With no accepted chip and no load, the register holds.
- R4: A `seed_load` cycle writes `seed_value` into the code register and restarts the partition at its first chip. A chip presented in that same cycle is ignored. Chips gathered before the load are discarded.
- R5: The partition sum is the exact signed sum of `CHIPS_PER_PART` consecutive accepted chips. The accumulator is cleared at each partition's first chip and is wide enough (`CHIP_W + clog2(CHIPS_PER_PART)`) never to overflow.
- R6: `part_valid` is high for exactly one cycle: the cycle after the clock edge that accepts a partition's last chip. It is never high otherwise.
- R7: `part_value` is the partition sum shifted arithmetically right by `SCALE_SHIFT`, which rounds toward minus infinity. The result is clamped to the signed `PART_W` range, −2^(PART_W−1) … 2^(PART_W−1)−1, and given in two's complement.
- R8: `part_hard` is 1 when the scaled value is negative and 0 when it is zero or positive.
- R9: `part_value` and `part_hard` keep their values until the next result is produced.
- R10: Idle cycles between accepted chips, inside a partition or between partitions, do not change any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seed_load | input | 1 | Load `seed_value` into the code register and restart the partition |
| seed_value | input | 51 | Per-user initial state of the code register |
| chip_valid | input | 1 | `chip_in` carries a chip this cycle |
| chip_in | input | CHIP_W | Sign-magnitude chip sample, sign in the MSB |
| part_valid | output | 1 | One-cycle strobe: a new partition result is present |
| part_value | output | PART_W | Scaled, clamped partition value, two's complement |
| part_hard | output | 1 | Hard decision, 1 when `part_value` is negative |

## Verification
The bench aims at the scaler edges. Full-scale partitions of both signs must clamp to +127 and −128; a design that wraps instead of clamping returns a small value of the wrong sign. Sums of −1, −16, +15 and +16 expose truncation toward zero (−1 would read as 0) and a hard decision that treats zero as negative.

Negative-zero chips catch a conversion that yields −1 or −2^(H−1). Partitions run with the reset seed, an all-zero seed and random seeds will diverge on the first wrong tap or wrong shift direction. A load issued mid-partition together with a full-scale chip shows whether stale chips or the colliding chip leak into the next sum.

Gapped input and back-to-back partitions catch a counter that advances on idle cycles or a strobe that lands late or twice.

// File: rtl/pn_corr_pkg.sv
package pn_corr_pkg;

  // Length and feedback taps of the spreading-code register.
  // Bit 0 is stage 1; taps sit on stages 1 and 4.
  localparam int unsigned PN_STAGES = 51;
  localparam int unsigned PN_TAP_A  = 0;
  localparam int unsigned PN_TAP_B  = 3;

  typedef logic [PN_STAGES-1:0] pn_state_t;

  // One step of the code register: shift toward bit 0, feedback enters at the top.
  function automatic pn_state_t pn_advance(input pn_state_t s);
    return {s[PN_TAP_A] ^ s[PN_TAP_B], s[PN_STAGES-1:1]};
  endfunction

endpackage

// File: rtl/pn_seq_gen.sv
module pn_seq_gen
  import pn_corr_pkg::*;
#(
  parameter pn_state_t RESET_SEED = '1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  pn_state_t seed,
  input  logic      step,
  output pn_state_t state,
  output logic      pn_bit
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= RESET_SEED;
    end else if (load) begin
      state <= seed;
    end else if (step) begin
      state <= pn_advance(state);
    end
  end

  assign pn_bit = state[0];

endmodule

// File: rtl/chip_sign_gate.sv
module chip_sign_gate #(
  parameter int unsigned CHIP_W = 11,
  parameter int unsigned ACC_W  = 15
) (
  input  logic [CHIP_W-1:0]       chip,
  input  logic                    pn_bit,
  output logic signed [ACC_W-1:0] chip_tc
);

  localparam int unsigned MAG_W = CHIP_W - 1;

  // Sign-magnitude to two's complement at accumulator width; -0 maps to 0.
  function automatic logic signed [ACC_W-1:0] sm_to_tc(input logic neg,
                                                      input logic [MAG_W-1:0] mag);
    logic signed [ACC_W-1:0] ext;
    ext = signed'({{(ACC_W-MAG_W){1'b0}}, mag});
    return neg ? -ext : ext;
  endfunction

  logic despread_sign;

  // The code bit only touches the sign; the magnitude is never multiplied.
  assign despread_sign = chip[CHIP_W-1] ^ pn_bit;
  assign chip_tc       = sm_to_tc(despread_sign, chip[MAG_W-1:0]);

endmodule

// File: rtl/partition_accum.sv
module partition_accum #(
  parameter int unsigned CHIPS = 16,
  parameter int unsigned ACC_W = 15,
  parameter int unsigned CNT_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    restart,
  input  logic                    accept,
  input  logic signed [ACC_W-1:0] chip_tc,
  output logic signed [ACC_W-1:0] sum_now,
  output logic                    last_accept,
  output logic [CNT_W-1:0]        cnt
);

  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(CHIPS - 1);

  logic signed [ACC_W-1:0] acc;
  logic                    first_chip;

  assign first_chip  = (cnt == '0);
  // Clearing is folded into the add: the first chip of a partition ignores acc.
  assign sum_now     = (first_chip ? '0 : acc) + chip_tc;
  assign last_accept = accept && (cnt == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      acc <= '0;
    end else if (restart) begin
      cnt <= '0;
    end else if (accept) begin
      acc <= sum_now;
      cnt <= last_accept ? '0 : cnt + 1'b1;
    end
  end

endmodule

// File: rtl/partition_scaler.sv
module partition_scaler #(
  parameter int unsigned ACC_W  = 15,
  parameter int unsigned PART_W = 8,
  parameter int unsigned SHIFT  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fire,
  input  logic signed [ACC_W-1:0] sum_in,
  output logic                    part_valid,
  output logic [PART_W-1:0]       part_value,
  output logic                    part_hard
);

  localparam longint HI = (longint'(1) <<< (PART_W - 1)) - 1;
  localparam longint LO = -HI - 1;

  // Arithmetic shift (floor), then clamp into the signed output range.
  function automatic logic [PART_W-1:0] shift_sat(input logic signed [ACC_W-1:0] v);
    logic signed [ACC_W-1:0] sh;
    longint                  w;
    sh = v >>> SHIFT;
    w  = longint'(sh);
    if (w > HI)      w = HI;
    else if (w < LO) w = LO;
    return w[PART_W-1:0];
  endfunction

  logic [PART_W-1:0] scaled;

  assign scaled = shift_sat(sum_in);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      part_valid <= 1'b0;
      part_value <= '0;
      part_hard  <= 1'b0;
    end else begin
      part_valid <= fire;
      if (fire) begin
        part_value <= scaled;
        part_hard  <= scaled[PART_W-1];
      end
    end
  end

endmodule

// File: rtl/pn_despread_correlator.sv
module pn_despread_correlator
  import pn_corr_pkg::*;
#(
  parameter int unsigned CHIP_W         = 11,
  parameter int unsigned PART_W         = 8,
  parameter int unsigned CHIPS_PER_PART = 16,
  parameter int unsigned SCALE_SHIFT    = 4,
  parameter pn_state_t   RESET_SEED     = '1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 seed_load,
  input  logic [PN_STAGES-1:0] seed_value,
  input  logic                 chip_valid,
  input  logic [CHIP_W-1:0]    chip_in,
  output logic                 part_valid,
  output logic [PART_W-1:0]    part_value,
  output logic                 part_hard
);

  localparam int unsigned GROW_W = (CHIPS_PER_PART > 1) ? $clog2(CHIPS_PER_PART) : 0;
  localparam int unsigned ACC_W  = CHIP_W + GROW_W;
  localparam int unsigned CNT_W  = (CHIPS_PER_PART > 1) ? $clog2(CHIPS_PER_PART) : 1;

  // Internal events, named for the checker.
  logic                    chip_accept;
  logic                    pn_bit;
  pn_state_t               pn_state;
  logic signed [ACC_W-1:0] chip_tc;
  logic signed [ACC_W-1:0] acc_sum;
  logic                    last_accept;
  logic [CNT_W-1:0]        part_cnt;

  // A load owns the cycle; a chip arriving with it is dropped.
  assign chip_accept = chip_valid && !seed_load;

  pn_seq_gen #(
    .RESET_SEED (RESET_SEED)
  ) u_pn (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (seed_load),
    .seed   (seed_value),
    .step   (chip_accept),
    .state  (pn_state),
    .pn_bit (pn_bit)
  );

  chip_sign_gate #(
    .CHIP_W (CHIP_W),
    .ACC_W  (ACC_W)
  ) u_gate (
    .chip    (chip_in),
    .pn_bit  (pn_bit),
    .chip_tc (chip_tc)
  );

  partition_accum #(
    .CHIPS (CHIPS_PER_PART),
    .ACC_W (ACC_W),
    .CNT_W (CNT_W)
  ) u_acc (
    .clk         (clk),
    .rst_n       (rst_n),
    .restart     (seed_load),
    .accept      (chip_accept),
    .chip_tc     (chip_tc),
    .sum_now     (acc_sum),
    .last_accept (last_accept),
    .cnt         (part_cnt)
  );

  partition_scaler #(
    .ACC_W  (ACC_W),
    .PART_W (PART_W),
    .SHIFT  (SCALE_SHIFT)
  ) u_scale (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (last_accept),
    .sum_in     (acc_sum),
    .part_valid (part_valid),
    .part_value (part_value),
    .part_hard  (part_hard)
  );

endmodule

// File: rtl/pn_corr_checker.sv
module pn_corr_checker
  import pn_corr_pkg::*;
#(
  parameter int unsigned CHIPS  = 16,
  parameter int unsigned PART_W = 8,
  parameter int unsigned CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              seed_load,
  input pn_state_t         seed_value,
  input logic              chip_valid,
  input pn_state_t         pn_state,
  input logic [CNT_W-1:0]  part_cnt,
  input logic              last_accept,
  input logic              part_valid,
  input logic [PART_W-1:0] part_value,
  input logic              part_hard
);

  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(CHIPS - 1);

  assert_pn_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!chip_valid && !seed_load) |=> $stable(pn_state));

  assert_seed_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load |=> (pn_state == $past(seed_value)) && (part_cnt == '0));

  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    part_cnt <= LAST_IDX);

  assert_strobe_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    part_valid |-> $past(last_accept));

  assert_strobe_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    last_accept |=> part_valid);

  assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !last_accept |=> $stable(part_value) && $stable(part_hard));

  generate
    if (CHIPS > 1) begin : g_pulse
      assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        part_valid |=> !part_valid);
    end
  endgenerate

endmodule

bind pn_despread_correlator pn_corr_checker #(
  .CHIPS  (CHIPS_PER_PART),
  .PART_W (PART_W),
  .CNT_W  (CNT_W)
) i_pn_corr_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .seed_load   (seed_load),
  .seed_value  (seed_value),
  .chip_valid  (chip_valid),
  .pn_state    (pn_state),
  .part_cnt    (part_cnt),
  .last_accept (last_accept),
  .part_valid  (part_valid),
  .part_value  (part_value),
  .part_hard   (part_hard)
);

// File: tb/test_pn_despread_correlator.sv
`timescale 1ns/1ps
module test_pn_despread_correlator;

  localparam int CHIP_W = 11;
  localparam int PART_W = 8;
  localparam int NCHIP  = 16;
  localparam int SHIFT  = 4;
  localparam int MAGMAX = (1 << (CHIP_W - 1)) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              seed_load = 1'b0;
  logic [50:0]       seed_value = '0;
  logic              chip_valid = 1'b0;
  logic [CHIP_W-1:0] chip_in = '0;
  logic              part_valid;
  logic [PART_W-1:0] part_value;
  logic              part_hard;

  always #4 clk = ~clk;

  pn_despread_correlator i_pn_despread_correlator (
    .clk        (clk),
    .rst_n      (rst_n),
    .seed_load  (seed_load),
    .seed_value (seed_value),
    .chip_valid (chip_valid),
    .chip_in    (chip_in),
    .part_valid (part_valid),
    .part_value (part_value),
    .part_hard  (part_hard)
  );

  typedef struct {
    logic [PART_W-1:0] val;
    logic              hard;
    string             tag;
  } exp_t;

  exp_t  expq[$];
  int    checks = 0;
  int    failures = 0;
  bit    started = 0;
  bit    done = 0;
  string cur_tag = "R5";

  // Bench-side reference state
  logic [50:0] m_pn = '1;
  int          m_sum = 0;
  int          m_cnt = 0;

  function automatic exp_t make_exp(input int sum, input string tag);
    exp_t e;
    int   d;
    int   q;
    d = 1 << SHIFT;
    if (sum >= 0) q = sum / d;
    else          q = -((-sum + d - 1) / d);
    if (q > 127)  q = 127;
    if (q < -128) q = -128;
    e.val  = q[PART_W-1:0];
    e.hard = (q < 0);
    e.tag  = tag;
    return e;
  endfunction

  task automatic put_chip(input logic [CHIP_W-1:0] c);
    int v;
    int mag;
    @(negedge clk);
    seed_load  = 1'b0;
    chip_valid = 1'b1;
    chip_in    = c;
    mag = int'(c[CHIP_W-2:0]);
    v   = (c[CHIP_W-1] ^ m_pn[0]) ? -mag : mag;
    m_sum = ((m_cnt == 0) ? 0 : m_sum) + v;
    m_pn  = {m_pn[0] ^ m_pn[3], m_pn[50:1]};
    m_cnt++;
    if (m_cnt == NCHIP) begin
      expq.push_back(make_exp(m_sum, cur_tag));
      m_cnt = 0;
    end
  endtask

  // Send a chip whose despread value is v.
  task automatic send_val(input int v);
    logic neg;
    int   mag;
    neg = (v < 0);
    mag = neg ? -v : v;
    put_chip({neg ^ m_pn[0], mag[CHIP_W-2:0]});
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      chip_valid = 1'b0;
      seed_load  = 1'b0;
    end
  endtask

  task automatic load_seed(input logic [50:0] s, input bit with_chip);
    @(negedge clk);
    seed_load  = 1'b1;
    seed_value = s;
    chip_valid = with_chip;
    chip_in    = {1'b0, MAGMAX[CHIP_W-2:0]};
    m_pn  = s;
    m_cnt = 0;
  endtask

  task automatic note(input bit ok, input string tag, input string what,
                      input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Monitor: compares each result with the scoreboard, checks holding between results.
  logic [PART_W-1:0] last_val = '0;
  logic              last_hard = 1'b0;
  always @(negedge clk) begin
    if (started && rst_n) begin
      if (part_valid) begin
        if (expq.size() == 0) begin
          note(1'b0, "R6", "unexpected part_valid", 1, 0);
        end else begin
          exp_t e;
          e = expq.pop_front();
          note(part_value == e.val, e.tag, "part_value",
               int'($signed(part_value)), int'($signed(e.val)));
          note(part_hard == e.hard, e.tag == "R7" ? "R8" : e.tag, "part_hard",
               int'(part_hard), int'(e.hard));
        end
      end else begin
        note(part_value == last_val && part_hard == last_hard, "R9", "held value",
             int'($signed(part_value)), int'($signed(last_val)));
      end
      last_val  = part_value;
      last_hard = part_hard;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R6 watchdog actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    note(part_valid == 1'b0, "R1", "part_valid after reset", int'(part_valid), 0);
    note(part_value == '0,  "R1", "part_value after reset", int'(part_value), 0);
    note(part_hard == 1'b0, "R1", "part_hard after reset", int'(part_hard), 0);
    started = 1;

    // R1 / R3: reset seed (all ones), random raw chips
    cur_tag = "R3";
    repeat (3 * NCHIP) put_chip(CHIP_W'($urandom));
    idle(3);

    // R2: negative zero contributes nothing; one chip of +32 gives 2
    cur_tag = "R2";
    put_chip({1'b1, 10'd0});
    repeat (NCHIP - 2) put_chip({1'b1, 10'd0});
    send_val(32);
    idle(2);

    // R7: clamp high and low
    cur_tag = "R7";
    repeat (NCHIP) send_val(MAGMAX);
    repeat (NCHIP) send_val(-MAGMAX);
    // R7 / R8: floor toward minus infinity and zero counted non-negative
    send_val(-1); repeat (NCHIP - 1) send_val(0);
    send_val(15); repeat (NCHIP - 1) send_val(0);
    send_val(-16); repeat (NCHIP - 1) send_val(0);
    send_val(16); repeat (NCHIP - 1) send_val(0);
    cur_tag = "R8";
    repeat (NCHIP) send_val(0);
    idle(2);

    // R4: zero seed keeps code bit at 0
    cur_tag = "R4";
    load_seed('0, 1'b0);
    repeat (NCHIP) put_chip(CHIP_W'($urandom));
    // R4: mid-partition load with a colliding chip
    repeat (5) put_chip(CHIP_W'($urandom));
    load_seed({$urandom, $urandom} & 51'h7_FFFF_FFFF_FFFF, 1'b1);
    repeat (2 * NCHIP) put_chip(CHIP_W'($urandom));
    idle(2);

    // R10: gaps inside and between partitions
    cur_tag = "R10";
    for (int p = 0; p < 3; p++) begin
      for (int k = 0; k < NCHIP; k++) begin
        put_chip(CHIP_W'($urandom));
        if ((k % 3) == 1) idle(1 + (k % 4));
      end
      idle(p);
    end

    // R5 / R6: long back-to-back run under a random seed
    cur_tag = "R5";
    load_seed({$urandom, $urandom} & 51'h7_FFFF_FFFF_FFFF, 1'b0);
    repeat (6 * NCHIP) put_chip(CHIP_W'($urandom));
    idle(5);

    // R6: every expected result must have appeared
    note(expq.size() == 0, "R6", "pending results", expq.size(), 0);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule